// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus (SCL clock, SDA data driven open-drain) that lets a host read and write a bank of 22 eight-bit control registers. The bank is also brought out in parallel so that the surrounding logic can use every field directly. The bus lines are oversampled with a fast system clock. A two-stage synchroniser feeds an edge detector, and a byte-level state machine runs from the detector's outputs.

The slave answers to the 7-bit address 69h, which gives D2h on the wire for writes and D3h for reads. The command byte selects the access style. With bit 7 set, it addresses a single register whose index is in bits 6:0. A command of exactly 00h starts a block transfer at register 0. A block write carries a byte count and then that many data bytes. A block read returns a count byte of 16h (22) and then the registers in ascending order. The index wraps from 21 back to 0.

Two registers are read-only constants. Index 6 holds 50h and index 7 holds 70h. The five low bits of register 1 are not stored at all and always show the live power-up strap inputs.

Top module: `smb_regbank`

## Requirements
- R1: After reset the bank holds 10h, E2h-with-straps, FFh, FFh, BFh, 02h, 50h, 70h, 90h, 7Ah, BBh, 0Bh, FBh, 0Fh, 0Ah, 2Ch, 24h, 00h, 00h, D2h, 08h, 00h for indices 0 to 21. SDA is not driven.
- R2: An address byte of D2h or D3h is ACKed. Any other address is NACKed, and the transfer then has no effect on the bank.
- R3: A byte write consists of address D2h, a command with bit 7 set and index bits 6:0 below 22, and one data byte. It writes that register. A second data byte is NACKed and not written. A byte command with an index of 22 or more is NACKed.
- R4: A byte read consists of D2h, a byte command, a repeated START and D3h. It returns the addressed register MSB first. Each master ACK makes the slave send the next register.
- R5: A block write consists of D2h, command 00h, a count byte N and data bytes. The data bytes are written to registers 0, 1, 2 and onward. Data bytes after the N-th are NACKed and not written. A command with bit 7 clear that is not 00h is NACKed.
- R6: A block read consists of D2h, command 00h, a repeated START and D3h. The first byte returned is 16h, followed by register 0, register 1 and onward.
- R7: In block and multi-byte transfers, the register index after 21 is 0.
- R8: Register 6 always reads 50h and register 7 always reads 70h. Writes to them are ACKed and ignored.
- R9: Bits 4:0 of register 1 always equal the strap input. Writes change only bits 7:5.
- R10: A STOP at any point returns the slave to idle with SDA released. A later START with D3h reads the register chosen by the last command.
- R11: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| strap_fs_i | input | 5 | Power-up strap levels shown in register 1 bits 4:0 |
| regs_o | output | 176 | Register bank; register k occupies bits 8k+7:8k |

## Verification
The bench targets four kinds of corner case.

- Count-limited and single-byte writes. A design that ignores the count or the one-byte limit would write past the end and still ACK, which corrupts the neighbouring registers.
- Block reads and writes longer than the bank. A design with a missing wrap would step into non-existent indices, and a design that forgot the count byte would shift every returned register by one.
- Writes aimed at the constant registers and at the strapped bits, with the strap inputs toggled between transfers. A design that latches the straps or stores writes to the constants diverges from the model.
- Foreign addresses and transfers aborted by STOP. The reference model must see no change to the bank, and the pointer must survive for the next read.

// File: rtl/smb_regbank_pkg.sv
package smb_regbank_pkg;

  localparam int unsigned RSV_IDX   = 6;
  localparam logic [7:0]  RSV_VAL   = 8'h50;
  localparam int unsigned ID_IDX    = 7;
  localparam logic [7:0]  ID_VAL    = 8'h70;
  localparam int unsigned STRAP_IDX = 1;
  localparam int unsigned STRAP_W   = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } bus_st_e;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_CNT, K_DATA
  } rx_kind_e;

  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      0:  return 8'h10;
      1:  return 8'hE2;
      2:  return 8'hFF;
      3:  return 8'hFF;
      4:  return 8'hBF;
      5:  return 8'h02;
      8:  return 8'h90;
      9:  return 8'h7A;
      10: return 8'hBB;
      11: return 8'h0B;
      12: return 8'hFB;
      13: return 8'h0F;
      14: return 8'h0A;
      15: return 8'h2C;
      16: return 8'h24;
      19: return 8'hD2;
      20: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_s      = sda_sh[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges with the clock held high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
  import smb_regbank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 22,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      widx_i,
  input  logic [7:0]            wdata_i,
  input  logic [IDX_W-1:0]      ridx_i,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic [7:0] view [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] DFLT = reg_default(i);
    if (i == RSV_IDX) begin : g_rsv
      assign view[i] = RSV_VAL;
    end else if (i == ID_IDX) begin : g_id
      assign view[i] = ID_VAL;
    end else if (i == STRAP_IDX) begin : g_strap
      logic [7-STRAP_W:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                hi_q <= DFLT[7:STRAP_W];
        else if (we_i && widx_i == IDX_W'(i))       hi_q <= wdata_i[7:STRAP_W];
      end
      assign view[i] = {hi_q, strap_i};
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                q <= DFLT;
        else if (we_i && widx_i == IDX_W'(i))       q <= wdata_i;
      end
      assign view[i] = q;
    end
    assign regs_o[i*8 +: 8] = view[i];
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ridx_i == IDX_W'(i)) rdata_o = view[i];
    end
  end

endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import smb_regbank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 22,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rdata_i,
  output logic [IDX_W-1:0] ridx_o,
  output logic             we_o,
  output logic [IDX_W-1:0] widx_o,
  output logic [7:0]       wdata_o,
  output logic             sda_oe_o
);

  localparam logic [7:0]       NUM_B = 8'(NUM_REGS);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_REGS - 1);

  bus_st_e    st;
  rx_kind_e   kind;
  logic [3:0] bit_cnt;
  logic [7:0] sh, tx_sh, left;
  logic [IDX_W-1:0] ptr, ptr_nxt;
  logic       oe, ack_q, go_tx, cnt_first, m_ack;
  logic       rx_ack;
  logic [7:0] tx_byte;

  assign ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign tx_byte = cnt_first ? NUM_B : rdata_i;

  always_comb begin
    unique case (kind)
      K_ADDR:  rx_ack = (sh[7:1] == DEV_ADDR);
      K_CMD:   rx_ack = (sh == 8'h00) || (sh[7] && ({1'b0, sh[6:0]} < NUM_B));
      K_CNT:   rx_ack = 1'b1;
      default: rx_ack = (left != 8'h00);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; kind <= K_ADDR; bit_cnt <= '0;
      sh <= '0; tx_sh <= '0; left <= '0; ptr <= '0;
      oe <= 1'b0; ack_q <= 1'b0; go_tx <= 1'b0; cnt_first <= 1'b0; m_ack <= 1'b0;
      we_o <= 1'b0; widx_o <= '0; wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        st <= ST_RX; kind <= K_ADDR; bit_cnt <= '0; oe <= 1'b0;
      end else if (stop_i) begin
        st <= ST_IDLE; oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise_i) begin
              sh      <= {sh[6:0], sda_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall_i && bit_cnt == 4'd8) begin
              st    <= ST_RX_ACK;
              oe    <= rx_ack;
              ack_q <= rx_ack;
              go_tx <= 1'b0;
              if (rx_ack) begin
                unique case (kind)
                  K_ADDR: begin
                    if (sh[0]) go_tx <= 1'b1;
                    else       kind  <= K_CMD;
                  end
                  K_CMD: begin
                    if (sh[7]) begin
                      ptr <= sh[IDX_W-1:0]; left <= 8'd1;
                      cnt_first <= 1'b0; kind <= K_DATA;
                    end else begin
                      ptr <= '0; cnt_first <= 1'b1; kind <= K_CNT;
                    end
                  end
                  K_CNT: begin
                    left <= sh; kind <= K_DATA;
                  end
                  default: begin
                    we_o <= 1'b1; widx_o <= ptr; wdata_o <= sh;
                    ptr  <= ptr_nxt; left <= left - 8'd1;
                  end
                endcase
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              if (ack_q && go_tx) begin
                tx_sh <= tx_byte; oe <= ~tx_byte[7]; st <= ST_TX; bit_cnt <= '0;
                if (cnt_first) cnt_first <= 1'b0;
                else           ptr <= ptr_nxt;
              end else if (ack_q) begin
                st <= ST_RX; bit_cnt <= '0; oe <= 1'b0;
              end else begin
                st <= ST_IDLE; oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_cnt == 4'd8) begin
                oe <= 1'b0; st <= ST_TX_ACK;
              end else begin
                tx_sh <= {tx_sh[6:0], 1'b0};
                oe    <= ~tx_sh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              m_ack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (m_ack) begin
                tx_sh <= tx_byte; oe <= ~tx_byte[7]; st <= ST_TX; bit_cnt <= '0;
                if (cnt_first) cnt_first <= 1'b0;
                else           ptr <= ptr_nxt;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: oe <= 1'b0;
        endcase
      end
    end
  end

  assign ridx_o   = ptr;
  assign sda_oe_o = oe;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_regbank_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 22,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [STRAP_W-1:0]    strap_fs_i,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic             sda_w, rise_w, fall_w, start_w, stop_w;
  logic             we_w;
  logic [IDX_W-1:0] widx_w, ridx_w;
  logic [7:0]       wdata_w, rdata_w;

  smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_w), .scl_rise_o(rise_w), .scl_fall_o(fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  smb_slave_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni,
    .sda_i(sda_w), .scl_rise_i(rise_w), .scl_fall_i(fall_w),
    .start_i(start_w), .stop_i(stop_w),
    .rdata_i(rdata_w), .ridx_o(ridx_w),
    .we_o(we_w), .widx_o(widx_w), .wdata_o(wdata_w),
    .sda_oe_o
  );

  smb_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(we_w), .widx_i(widx_w), .wdata_i(wdata_w),
    .ridx_i(ridx_w), .strap_i(strap_fs_i),
    .rdata_o(rdata_w), .regs_o
  );

endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk
  import smb_regbank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 22,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic [STRAP_W-1:0]    strap_fs_i,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  start_w,
  input logic                  stop_w,
  input logic                  we_w,
  input logic [IDX_W-1:0]      widx_w,
  input logic [7:0]            wdata_w
);

  logic             we_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       dat_q, sel_b;
  logic             ro_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b0; idx_q <= '0; dat_q <= '0;
    end else begin
      we_q <= we_w; idx_q <= widx_w; dat_q <= wdata_w;
    end
  end

  always_comb begin
    sel_b = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx_q == IDX_W'(i)) sel_b = regs_o[i*8 +: 8];
    end
  end

  assign ro_q = (int'(idx_q) == STRAP_IDX) || (int'(idx_q) == RSV_IDX) || (int'(idx_q) == ID_IDX);

  // R11
  sda_pull_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_oe_o);

  // R2
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> !sda_oe_o);

  // R7
  wr_index_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_w |-> (int'(widx_w) < NUM_REGS));

  // R5
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && !ro_q) |-> (sel_b == dat_q));

  // R8
  const_reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_w && (int'(widx_w) == RSV_IDX || int'(widx_w) == ID_IDX))
      |=> ($stable(regs_o[RSV_IDX*8 +: 8]) && $stable(regs_o[ID_IDX*8 +: 8])));

  // R9
  strap_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_w && int'(widx_w) == STRAP_IDX)
      |=> (regs_o[STRAP_IDX*8 +: STRAP_W] == strap_fs_i));

endmodule

bind smb_regbank smb_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/smb_regbank_test.sv
module smb_regbank_test;

  localparam int N = 22;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [4:0] strap = 5'b00010;
  logic sda_oe;
  logic [N*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  smb_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_fs_i(strap), .regs_o(regs)
  );

  int    vecs = 0, errs = 0;
  bit    cmp_on = 1'b0, done = 1'b0;
  string cur_req = "R1";
  logic [7:0] mdl [N];
  logic  oe_prev = 1'b0;

  function automatic logic [7:0] mview(int i);
    if (i == 6) return 8'h50;
    if (i == 7) return 8'h70;
    if (i == 1) return {mdl[1][7:5], strap};
    return mdl[i];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mwr(int i, logic [7:0] v);
    if (i != 6 && i != 7) mdl[i] = v;
  endtask

  // per-clock comparison of the whole bank while the bus is idle
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < N; i++) chk(cur_req, $sformatf("reg%0d", i), regs[i*8 +: 8], mview(i));
      chk("R10", "idle sda_oe", sda_oe, 0);
    end
  end

  // R11: slave may start pulling SDA only while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev) chk("R11", "sda pull with scl", scl_m, 0);
    oe_prev <= sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic v, output logic got);
    sda_m = v; tick(H);
    scl_m = 1'b1; tick(H/2);
    got = sda_line; tick(H/2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_start;
    cmp_on = 1'b0;
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
    cmp_on = 1'b1;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bit_io(b[i], g);
    bit_io(1'b1, g);
    ack = ~g;
  endtask

  task automatic get_byte(output logic [7:0] b, input logic mack);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, g);
      b[i] = g;
    end
    bit_io(~mack, g);
  endtask

  task automatic byte_write(int idx, logic [7:0] v, logic exp_ack, string req);
    logic a;
    cur_req = req;
    bus_start;
    put_byte(8'hD2, a);                 chk("R2", "addr D2 ack", a, 1);
    put_byte(8'h80 | 8'(idx), a);       chk(req, "byte cmd ack", a, exp_ack);
    if (exp_ack) begin
      put_byte(v, a);                   chk(req, "byte data ack", a, 1);
      mwr(idx, v);
    end
    bus_stop;
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    mdl = '{8'h10, 8'hE2, 8'hFF, 8'hFF, 8'hBF, 8'h02, 8'h50, 8'h70, 8'h90, 8'h7A, 8'hBB,
            8'h0B, 8'hFB, 8'h0F, 8'h0A, 8'h2C, 8'h24, 8'h00, 8'h00, 8'hD2, 8'h08, 8'h00};
    tick(5);
    rst_n = 1'b1;
    tick(2);
    cmp_on = 1'b1;              // R1 defaults compared per clock
    tick(10);

    // R2 foreign addresses are NACKed
    cur_req = "R2";
    bus_start; put_byte(8'hA4, a); chk("R2", "addr A4 nack", a, 0); bus_stop;
    bus_start; put_byte(8'hD0, a); chk("R2", "addr D0 nack", a, 0);
    put_byte(8'h83, a); put_byte(8'h00, a); bus_stop;

    // R3 byte write, second data byte refused, out-of-range index
    byte_write(3, 8'h5A, 1'b1, "R3");
    cur_req = "R3";
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h84, a); chk("R3", "cmd 84 ack", a, 1);
    put_byte(8'h11, a); chk("R3", "first data ack", a, 1); mwr(4, 8'h11);
    put_byte(8'h22, a); chk("R3", "second data nack", a, 0);
    bus_stop;
    byte_write(22, 8'h99, 1'b0, "R3");

    // R4 byte read with continuation
    cur_req = "R4";
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h83, a);
    bus_start;
    put_byte(8'hD3, a); chk("R2", "addr D3 ack", a, 1);
    get_byte(b, 1'b1); chk("R4", "read reg3", b, mview(3));
    get_byte(b, 1'b0); chk("R4", "read reg4 continue", b, mview(4));
    bus_stop;

    // R5 block write limited by count, bad block command
    cur_req = "R5";
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h00, a); chk("R5", "block cmd ack", a, 1);
    put_byte(8'h03, a); chk("R5", "count ack", a, 1);
    for (int k = 0; k < 3; k++) begin
      put_byte(8'hA1 + 8'(k), a); chk("R5", "block data ack", a, 1); mwr(k, 8'hA1 + 8'(k));
    end
    put_byte(8'hEE, a); chk("R5", "beyond count nack", a, 0);
    bus_stop;
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h05, a); chk("R5", "cmd 05 nack", a, 0);
    bus_stop;

    // R8 constant registers, R9 strap bits
    byte_write(6, 8'hFF, 1'b1, "R8");
    byte_write(7, 8'h00, 1'b1, "R8");
    byte_write(1, 8'h1F, 1'b1, "R9");
    cur_req = "R9";
    strap = 5'b10101; tick(4);
    strap = 5'b01000; tick(4);

    // R6 block read with R7 wrap
    cur_req = "R6";
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h00, a);
    bus_start;
    put_byte(8'hD3, a);
    get_byte(b, 1'b1); chk("R6", "count byte", b, 8'h16);
    for (int k = 0; k < N + 2; k++) begin
      get_byte(b, k != N + 1);
      chk(k < N ? "R6" : "R7", $sformatf("block read %0d", k), b, mview(k % N));
    end
    bus_stop;

    // R7 block write of 23 bytes wraps onto register 0
    cur_req = "R7";
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'd23, a);
    for (int k = 0; k < 23; k++) begin
      put_byte(8'h30 + 8'(k), a); chk("R7", "wrap data ack", a, 1); mwr(k % N, 8'h30 + 8'(k));
    end
    bus_stop;

    // R10 aborted transfer, then direct read
    cur_req = "R10";
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h85, a);
    bus_stop;
    tick(4);
    chk("R10", "released after stop", sda_oe, 0);
    bus_start;
    put_byte(8'hD3, a); chk("R10", "direct read ack", a, 1);
    get_byte(b, 1'b0); chk("R10", "read reg5 after abort", b, mview(5));
    bus_stop;
    tick(20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule